// File: doc/BRIEF.md
# Multi-Slot Cipher Key Store

This block holds up to eight cipher keys in separate slots and moves them in and out one machine word at a time. Software first picks a global key length, then arms one slot with a one-hot select and streams key words into it from a DMA-style input port. Once the last word lands, the slot is marked valid in a bitmap that software reads to confirm that the store worked. Changing the key length, or invalidating a slot on command, withdraws keys from use.

A load request names a slot. If that slot holds a valid key, the block raises a busy bit and presents the key on a word-wide output to the cipher engine's key register, one word per cycle, then drops busy. A successful load raises no interrupt. Faults do: a malformed or unexpected write raises a write-error flag, and a load from an empty slot raises a read-error flag. Every flag is sticky until software clears it.

Top module: `key_slot_store`

## Requirements
- R1: After reset the key-length code is 0, every slot is invalid, busy is low, no flag is set and the key output strobe is low.
- R2: Any write to the key-length register invalidates every slot, even when the code is unchanged, and cancels an armed write. Codes are 0 = 128 bits, 1 = 192 bits, 2 = 256 bits, and 3 behaves as 256 bits.
- R3: A write of the area select with exactly one bit n set arms slot n and clears slot n's valid bit in the same edge. Any other value sets the write-error flag (status bit 2) and arms nothing.
- R4: An armed write takes 4 words for code 0 and 8 words for codes 1 to 3. Word k is stored as key word k. After the last word, the slot's valid bit is set and input-done (bit 0) and result-available (bit 1) are set.
- R5: With code 1, words 6 and 7 must be zero. If either is not, the last word sets write-error and input-done but not result-available, and the slot stays invalid.
- R6: A stream word that arrives with no armed write sets write-error and is discarded.
- R7: An invalidate command clears the named slot's valid bit. If it coincides with the completion of a write to that same slot, the slot ends up invalid.
- R8: A load request to a valid slot while idle raises busy for exactly N cycles, where N is the word count of the code current at the request. In cycle k the key strobe is high with index k and the stored word k. Busy then falls and no flag is set.
- R9: A load request to an invalid slot sets read-error (status bit 3), and busy stays low.
- R10: A load request made while busy is ignored.
- R11: Status flags are sticky and are cleared by ones on the clear input. If a flag is set and cleared in the same cycle, the set wins.
- R12: A stream word arriving in the same cycle as an area-select write or a key-length write is dropped without any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_we | input | 1 | Write strobe for the key-length register |
| size_code | input | 2 | Key-length code |
| area_we | input | 1 | Write strobe for the area select |
| area_onehot | input | 8 | One-hot slot select for the next write |
| inval_we | input | 1 | Invalidate-slot command |
| inval_slot | input | 3 | Slot to invalidate |
| din_valid | input | 1 | Stream word valid |
| din_word | input | 32 | Stream key word |
| rd_we | input | 1 | Load request strobe |
| rd_slot | input | 3 | Slot to load |
| irq_clr | input | 4 | Write-one-to-clear for the status flags |
| size_q | output | 2 | Current key-length code |
| written_map | output | 8 | Per-slot valid bitmap |
| rd_busy | output | 1 | Load transfer in progress |
| irq_stat | output | 4 | Sticky flags: 0 input-done, 1 result, 2 write-error, 3 read-error |
| key_we | output | 1 | Key word strobe to the cipher engine |
| key_idx | output | 3 | Index of the presented key word |
| key_word | output | 32 | Presented key word |

## Verification
Two events can collide on a valid bit: the completion of a write can fall in the same cycle as an invalidate command for that slot. The bench also makes flag setting coincide with flag clearing. Both collisions are provoked by holding the invalidate or the clear on the cycle that carries the final stream word. A behavioural model, updated on every edge, judges them, and explicit checks confirm that the slot is invalid and that input-done is still set. The bench also lands stream words on area-select and key-length writes to prove that those words are dropped.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int IRQ_W       = 4;
  localparam int IRQ_IN_DONE = 0;
  localparam int IRQ_RESULT  = 1;
  localparam int IRQ_WR_ERR  = 2;
  localparam int IRQ_RD_ERR  = 3;

  typedef enum logic [1:0] {
    KSZ_128 = 2'd0,
    KSZ_192 = 2'd1,
    KSZ_256 = 2'd2,
    KSZ_RSV = 2'd3
  } ksz_e;
endpackage

// File: rtl/ks_writer.sv
module ks_writer
  import ks_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     size_we,
  input  ksz_e                     size_cur,
  input  logic                     area_we,
  input  logic [NSLOT-1:0]         area_onehot,
  input  logic                     din_valid,
  input  logic [WORD_W-1:0]        din_word,
  output logic [NSLOT-1:0]         arm_clr,
  output logic                     mem_we,
  output logic [$clog2(NSLOT)-1:0] mem_slot,
  output logic [$clog2(256/WORD_W)-1:0] mem_idx,
  output logic [WORD_W-1:0]        mem_data,
  output logic                     commit_ok,
  output logic [$clog2(NSLOT)-1:0] commit_slot,
  output logic                     in_done,
  output logic                     wr_err
);
  localparam int W128  = 128 / WORD_W;
  localparam int W256  = 256 / WORD_W;
  localparam int ZW    = 64 / WORD_W;
  localparam int IW    = $clog2(NSLOT);
  localparam int CNT_W = $clog2(W256);
  localparam logic [CNT_W-1:0] LAST128 = CNT_W'(W128 - 1);
  localparam logic [CNT_W-1:0] LAST256 = CNT_W'(W256 - 1);
  localparam logic [CNT_W-1:0] ZSTART  = CNT_W'(W256 - ZW);

  logic             armed_q, armed_d;
  logic [IW-1:0]    slot_q, slot_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bad_q, bad_d;
  logic [IW-1:0]    enc;
  logic [CNT_W-1:0] last;
  logic             bad_now;

  always_comb begin
    enc = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (area_onehot[i]) enc = IW'(i);
    end
  end

  assign last = (size_cur == KSZ_128) ? LAST128 : LAST256;
  assign bad_now = bad_q | ((size_cur == KSZ_192) && (cnt_q >= ZSTART) && (din_word != '0));

  always_comb begin
    armed_d     = armed_q;
    slot_d      = slot_q;
    cnt_d       = cnt_q;
    bad_d       = bad_q;
    arm_clr     = '0;
    mem_we      = 1'b0;
    commit_ok   = 1'b0;
    in_done     = 1'b0;
    wr_err      = 1'b0;
    if (size_we) begin
      armed_d = 1'b0;
    end else if (area_we) begin
      if ($onehot(area_onehot)) begin
        armed_d = 1'b1;
        slot_d  = enc;
        cnt_d   = '0;
        bad_d   = 1'b0;
        arm_clr = area_onehot;
      end else begin
        wr_err = 1'b1;
      end
    end else if (din_valid) begin
      if (!armed_q) begin
        wr_err = 1'b1;
      end else begin
        mem_we = 1'b1;
        if (cnt_q == last) begin
          armed_d   = 1'b0;
          in_done   = 1'b1;
          wr_err    = bad_now;
          commit_ok = !bad_now;
        end else begin
          cnt_d = cnt_q + 1'b1;
          bad_d = bad_now;
        end
      end
    end
  end

  assign mem_slot    = slot_q;
  assign mem_idx     = cnt_q;
  assign mem_data    = din_word;
  assign commit_slot = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      slot_q  <= '0;
      cnt_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      slot_q  <= slot_d;
      cnt_q   <= cnt_d;
      bad_q   <= bad_d;
    end
  end

  // R4
  word_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && din_valid && !size_we && !area_we && cnt_q != last)
      |=> (armed_q && cnt_q == $past(cnt_q) + 1'b1));

  // R2
  size_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_we |=> !armed_q);
endmodule

// File: rtl/ks_store.sv
module ks_store
#(
  parameter int NSLOT  = 8,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     size_we,
  input  logic [NSLOT-1:0]         arm_clr,
  input  logic                     inval_we,
  input  logic [$clog2(NSLOT)-1:0] inval_slot,
  input  logic                     commit_ok,
  input  logic [$clog2(NSLOT)-1:0] commit_slot,
  input  logic                     mem_we,
  input  logic [$clog2(NSLOT)-1:0] mem_slot,
  input  logic [$clog2(256/WORD_W)-1:0] mem_idx,
  input  logic [WORD_W-1:0]        mem_data,
  input  logic [$clog2(NSLOT)-1:0] rd_slot,
  input  logic [$clog2(256/WORD_W)-1:0] rd_idx,
  output logic [WORD_W-1:0]        rd_word,
  output logic [NSLOT-1:0]         map
);
  localparam int W256 = 256 / WORD_W;

  logic [WORD_W-1:0] mem_q [NSLOT][W256];
  logic [NSLOT-1:0]  map_q, map_d;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    for (genvar w = 0; w < W256; w++) begin : g_word
      logic ce;
      assign ce = mem_we && (mem_slot == s) && (mem_idx == w);
      always_ff @(posedge clk) begin
        if (ce) mem_q[s][w] <= mem_data;
      end
    end
  end

  assign rd_word = mem_q[rd_slot][rd_idx];

  always_comb begin
    map_d = map_q;
    if (size_we) begin
      map_d = '0;
    end else begin
      map_d = map_d & ~arm_clr;
      if (commit_ok) map_d[commit_slot] = 1'b1;
      if (inval_we)  map_d[inval_slot]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  assign map = map_q;

  // R2
  size_clears_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_we |=> (map_q == '0));

  // R7
  inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_we |=> !map_q[$past(inval_slot)]);
endmodule

// File: rtl/ks_reader.sv
module ks_reader
  import ks_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_we,
  input  logic [$clog2(NSLOT)-1:0] rd_slot,
  input  ksz_e                     size_cur,
  input  logic [NSLOT-1:0]         map,
  output logic                     busy,
  output logic [$clog2(NSLOT)-1:0] slot,
  output logic [$clog2(256/WORD_W)-1:0] idx,
  output logic                     rd_err
);
  localparam int W128  = 128 / WORD_W;
  localparam int W256  = 256 / WORD_W;
  localparam int IW    = $clog2(NSLOT);
  localparam int CNT_W = $clog2(W256);
  localparam logic [CNT_W-1:0] LAST128 = CNT_W'(W128 - 1);
  localparam logic [CNT_W-1:0] LAST256 = CNT_W'(W256 - 1);

  logic             busy_q, busy_d;
  logic [IW-1:0]    slot_q, slot_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q, last_d;

  always_comb begin
    busy_d = busy_q;
    slot_d = slot_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    rd_err = 1'b0;
    if (busy_q) begin
      if (cnt_q == last_q) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (rd_we) begin
      if (map[rd_slot]) begin
        busy_d = 1'b1;
        slot_d = rd_slot;
        cnt_d  = '0;
        last_d = (size_cur == KSZ_128) ? LAST128 : LAST256;
      end else begin
        rd_err = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      busy_q <= busy_d;
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  assign busy = busy_q;
  assign slot = slot_q;
  assign idx  = cnt_q;

  // R8
  xfer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != last_q) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_we) |=> $stable(slot_q));
endmodule

// File: rtl/ks_irq.sv
module ks_irq
  import ks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set,
  input  logic [IRQ_W-1:0] clr,
  output logic [IRQ_W-1:0] stat
);
  logic [IRQ_W-1:0] stat_q, stat_d;

  assign stat_d = (stat_q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_chk
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> stat_q[i]);
  end
endmodule

// File: rtl/key_slot_store.sv
module key_slot_store
  import ks_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int WORD_W = 32,
  localparam int IW    = $clog2(NSLOT),
  localparam int CNT_W = $clog2(256 / WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              size_we,
  input  logic [1:0]        size_code,
  input  logic              area_we,
  input  logic [NSLOT-1:0]  area_onehot,
  input  logic              inval_we,
  input  logic [IW-1:0]     inval_slot,
  input  logic              din_valid,
  input  logic [WORD_W-1:0] din_word,
  input  logic              rd_we,
  input  logic [IW-1:0]     rd_slot,
  input  logic [3:0]        irq_clr,
  output logic [1:0]        size_q,
  output logic [NSLOT-1:0]  written_map,
  output logic              rd_busy,
  output logic [3:0]        irq_stat,
  output logic              key_we,
  output logic [CNT_W-1:0]  key_idx,
  output logic [WORD_W-1:0] key_word
);
  ksz_e              size_r;
  logic [NSLOT-1:0]  arm_clr;
  logic              mem_we;
  logic [IW-1:0]     mem_slot;
  logic [CNT_W-1:0]  mem_idx;
  logic [WORD_W-1:0] mem_data;
  logic              commit_ok;
  logic [IW-1:0]     commit_slot;
  logic              in_done;
  logic              wr_err;
  logic              rd_err;
  logic [IW-1:0]     xfer_slot;
  logic [IRQ_W-1:0]  irq_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       size_r <= KSZ_128;
    else if (size_we) size_r <= ksz_e'(size_code);
  end

  ks_writer #(.NSLOT(NSLOT), .WORD_W(WORD_W)) u_writer (
    .clk(clk), .rst_n(rst_n), .size_we(size_we), .size_cur(size_r),
    .area_we(area_we), .area_onehot(area_onehot),
    .din_valid(din_valid), .din_word(din_word),
    .arm_clr(arm_clr), .mem_we(mem_we), .mem_slot(mem_slot),
    .mem_idx(mem_idx), .mem_data(mem_data), .commit_ok(commit_ok),
    .commit_slot(commit_slot), .in_done(in_done), .wr_err(wr_err)
  );

  ks_store #(.NSLOT(NSLOT), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .size_we(size_we), .arm_clr(arm_clr),
    .inval_we(inval_we), .inval_slot(inval_slot),
    .commit_ok(commit_ok), .commit_slot(commit_slot),
    .mem_we(mem_we), .mem_slot(mem_slot), .mem_idx(mem_idx),
    .mem_data(mem_data), .rd_slot(xfer_slot), .rd_idx(key_idx),
    .rd_word(key_word), .map(written_map)
  );

  ks_reader #(.NSLOT(NSLOT), .WORD_W(WORD_W)) u_reader (
    .clk(clk), .rst_n(rst_n), .rd_we(rd_we), .rd_slot(rd_slot),
    .size_cur(size_r), .map(written_map), .busy(rd_busy),
    .slot(xfer_slot), .idx(key_idx), .rd_err(rd_err)
  );

  always_comb begin
    irq_set              = '0;
    irq_set[IRQ_IN_DONE] = in_done;
    irq_set[IRQ_RESULT]  = commit_ok;
    irq_set[IRQ_WR_ERR]  = wr_err;
    irq_set[IRQ_RD_ERR]  = rd_err;
  end

  ks_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .stat(irq_stat)
  );

  assign size_q = size_r;
  assign key_we = rd_busy;

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we && !rd_busy && !written_map[rd_slot]) |=> (irq_stat[IRQ_RD_ERR] && !rd_busy));

  // R3
  bad_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (area_we && !size_we && !$onehot(area_onehot)) |=> irq_stat[IRQ_WR_ERR]);
endmodule

// File: tb/key_slot_store_bench.sv
module key_slot_store_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        size_we, area_we, inval_we, din_valid, rd_we;
  logic [1:0]  size_code;
  logic [7:0]  area_onehot;
  logic [2:0]  inval_slot, rd_slot;
  logic [31:0] din_word;
  logic [3:0]  irq_clr;
  logic [1:0]  size_q;
  logic [7:0]  written_map;
  logic        rd_busy, key_we;
  logic [3:0]  irq_stat;
  logic [2:0]  key_idx;
  logic [31:0] key_word;

  int checks = 0;
  int errors = 0;
  bit run = 0;

  always #(PERIOD/2) clk = ~clk;

  key_slot_store u_key_slot_store (
    .clk(clk), .rst_n(rst_n), .size_we(size_we), .size_code(size_code),
    .area_we(area_we), .area_onehot(area_onehot), .inval_we(inval_we),
    .inval_slot(inval_slot), .din_valid(din_valid), .din_word(din_word),
    .rd_we(rd_we), .rd_slot(rd_slot), .irq_clr(irq_clr), .size_q(size_q),
    .written_map(written_map), .rd_busy(rd_busy), .irq_stat(irq_stat),
    .key_we(key_we), .key_idx(key_idx), .key_word(key_word)
  );

  // behavioural reference
  int          m_size;
  bit [7:0]    m_map;
  logic [31:0] m_mem [8][8];
  bit          m_armed, m_bad, m_busy;
  int          m_slot, m_cnt, m_rslot, m_rcnt, m_rlast;
  bit [3:0]    m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_size = 0; m_map = '0; m_armed = 0; m_bad = 0; m_busy = 0;
      m_slot = 0; m_cnt = 0; m_rslot = 0; m_rcnt = 0; m_rlast = 0; m_irq = '0;
      for (int s = 0; s < 8; s++) for (int w = 0; w < 8; w++) m_mem[s][w] = '0;
    end else begin
      bit [3:0] set;
      int words, commit;
      set = '0; commit = -1;
      words = (m_size == 0) ? 4 : 8;
      if (m_busy) begin
        if (m_rcnt == m_rlast) m_busy = 0; else m_rcnt++;
      end else if (rd_we) begin
        if (m_map[rd_slot]) begin
          m_busy = 1; m_rslot = int'(rd_slot); m_rcnt = 0; m_rlast = words - 1;
        end else set[3] = 1;
      end
      if (size_we) m_armed = 0;
      else if (area_we) begin
        if ($countones(area_onehot) == 1) begin
          for (int i = 0; i < 8; i++) if (area_onehot[i]) m_slot = i;
          m_armed = 1; m_cnt = 0; m_bad = 0; m_map[m_slot] = 0;
        end else set[2] = 1;
      end else if (din_valid) begin
        if (!m_armed) set[2] = 1;
        else begin
          m_mem[m_slot][m_cnt] = din_word;
          if (m_size == 1 && m_cnt >= 6 && din_word != 0) m_bad = 1;
          if (m_cnt == words - 1) begin
            m_armed = 0; set[0] = 1;
            if (m_bad) set[2] = 1; else begin set[1] = 1; commit = m_slot; end
          end else m_cnt++;
        end
      end
      if (size_we) begin m_map = '0; m_size = int'(size_code); end
      else begin
        if (commit >= 0) m_map[commit] = 1;
        if (inval_we) m_map[inval_slot] = 0;
      end
      m_irq = (m_irq & ~irq_clr) | set;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run && rst_n) begin
      chk(size_q == 2'(m_size), "R2 size", 32'(size_q), 32'(m_size));
      chk(written_map == m_map, "R4 map", 32'(written_map), 32'(m_map));
      chk(rd_busy == m_busy, "R8 busy", 32'(rd_busy), 32'(m_busy));
      chk(key_we == m_busy, "R8 key_we", 32'(key_we), 32'(m_busy));
      chk(irq_stat == m_irq, "R11 irq", 32'(irq_stat), 32'(m_irq));
      if (m_busy) begin
        chk(key_idx == 3'(m_rcnt), "R8 idx", 32'(key_idx), 32'(m_rcnt));
        chk(key_word == m_mem[m_rslot][m_rcnt], "R8 word", key_word, m_mem[m_rslot][m_rcnt]);
      end
    end
  end

  task automatic idle();
    size_we = 0; area_we = 0; inval_we = 0; din_valid = 0; rd_we = 0; irq_clr = '0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  task automatic set_size(int c);
    size_we = 1; size_code = 2'(c); step();
  endtask

  task automatic arm(logic [7:0] sel);
    area_we = 1; area_onehot = sel; step();
  endtask

  task automatic send(int n, logic [31:0] base, bit dirty);
    for (int k = 0; k < n; k++) begin
      din_valid = 1;
      din_word = (n == 8 && k >= 6 && !dirty && base[31]) ? 32'h0 : base + 32'(k);
      if (dirty && k == 7) din_word = 32'hDEAD0000;
      step();
    end
  endtask

  task automatic clear_all();
    irq_clr = 4'hF; step();
  endtask

  task automatic load(int s);
    rd_we = 1; rd_slot = 3'(s); step();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 12 && rd_busy; i++) step();
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); size_code = 0; area_onehot = 0; inval_slot = 0;
    rd_slot = 0; din_word = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(size_q == 0 && written_map == 0 && !rd_busy && irq_stat == 0 && !key_we,
        "R1 reset", {size_q, written_map, rd_busy, irq_stat, key_we}, 0);
    run = 1;
    @(posedge clk); #1;

    // R4 128-bit write into slot 3
    arm(8'h08); send(4, 32'h1000, 0);
    @(negedge clk);
    chk(written_map[3] && irq_stat[1:0] == 2'b11, "R4 commit", {written_map, irq_stat}, {8'h08, 4'h3});
    @(posedge clk); #1;
    // R8 load slot 3
    load(3); wait_idle();
    @(negedge clk);
    chk(irq_stat == 4'h3, "R8 no flag", irq_stat, 4'h3);
    @(posedge clk); #1;
    clear_all();

    // R2 size write invalidates, same value too
    set_size(2);
    @(negedge clk); chk(written_map == 0, "R2 invalidate", written_map, 0);
    @(posedge clk); #1;
    arm(8'h01); send(8, 32'h2000, 0);
    arm(8'h80); send(8, 32'h3000, 0);
    set_size(2);
    @(negedge clk); chk(written_map == 0, "R2 same code", written_map, 0);
    @(posedge clk); #1;
    arm(8'h01); send(8, 32'h2100, 0);
    load(0); wait_idle();
    clear_all();

    // R5 192-bit: clean key in slot 5, dirty key in slot 6
    set_size(1);
    arm(8'h20); send(8, 32'h8000_0000, 0);
    @(negedge clk); chk(written_map[5], "R5 clean", written_map, 8'h20);
    @(posedge clk); #1;
    clear_all();
    arm(8'h40); send(8, 32'h4000, 1);
    @(negedge clk);
    chk(!written_map[6] && irq_stat == 4'h5, "R5 dirty", {written_map, irq_stat}, {8'h20, 4'h5});
    @(posedge clk); #1;
    clear_all();

    // R3 bad select, R6 stray word
    arm(8'h03);
    @(negedge clk); chk(irq_stat == 4'h4, "R3 bad select", irq_stat, 4'h4);
    @(posedge clk); #1;
    clear_all();
    din_valid = 1; din_word = 32'h55; step();
    @(negedge clk); chk(irq_stat == 4'h4, "R6 stray", irq_stat, 4'h4);
    @(posedge clk); #1;
    clear_all();

    // R9 empty read
    load(6);
    @(negedge clk); chk(irq_stat[3] && !rd_busy, "R9 empty", {irq_stat, rd_busy}, 5'h10);
    @(posedge clk); #1;
    clear_all();

    // R10 load during busy
    load(5); load(0); step();
    @(negedge clk); chk(rd_busy && irq_stat == 0, "R10 ignored", {rd_busy, irq_stat}, 5'h10);
    @(posedge clk); #1;
    wait_idle();

    // R7 invalidate, and collision with commit
    inval_we = 1; inval_slot = 5; step();
    @(negedge clk); chk(!written_map[5], "R7 inval", written_map, 0);
    @(posedge clk); #1;
    set_size(0);
    arm(8'h04); send(3, 32'h7000, 0);
    din_valid = 1; din_word = 32'h7003; inval_we = 1; inval_slot = 2; irq_clr = 4'hF; step();
    @(negedge clk);
    chk(!written_map[2], "R7 collision", written_map, 0);
    // R11 set wins over clear
    chk(irq_stat[0] && irq_stat[1], "R11 set wins", irq_stat, 4'h3);
    @(posedge clk); #1;
    clear_all();

    // R12 word colliding with area write and size write
    arm(8'h02); send(2, 32'h9000, 0);
    area_we = 1; area_onehot = 8'h02; din_valid = 1; din_word = 32'hBAD; step();
    send(4, 32'h9100, 0);
    @(negedge clk);
    chk(written_map[1] && irq_stat == 4'h3, "R12 area drop", {written_map, irq_stat}, {8'h02, 4'h3});
    @(posedge clk); #1;
    clear_all();
    arm(8'h10); send(1, 32'hA000, 0);
    size_we = 1; size_code = 0; din_valid = 1; din_word = 32'hA001; step();
    @(negedge clk); chk(irq_stat == 0, "R12 size drop", irq_stat, 0);
    @(posedge clk); #1;
    // R2 write aborted by size write
    send(1, 32'hA002, 0);
    @(negedge clk); chk(irq_stat == 4'h4 && written_map == 0, "R2 abort", {written_map, irq_stat}, 12'h004);
    @(posedge clk); #1;

    repeat (3) step();
    run = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule